// File: doc/BRIEF.md
# Display control register decoder

This block sits on the control write port of a display controller. Each 32-bit write carries a command number in its top byte and parameters in the lower bits. The block decodes the command and updates one of several things: a 32-bit status word, a set of latched display geometry fields, or a readback register. The geometry fields are the scanout start point, the horizontal range and the vertical range. The status word holds the blanking flag, the DMA direction and the video mode bits. The readback register is loaded by information queries.

The readback register is filled from a bank of eight drawing-environment registers. A companion drawing-command path keeps that bank current through a separate write strobe. A full-reset command returns every piece of state to its power-up value. Both the full-reset and the command-reset commands send a one-cycle pulse that an external command FIFO uses to flush itself. All outputs come straight from registers, so a write takes effect on the output in the cycle after its clock edge.

Top module: `disp_ctrl_dec`

## Requirements
- R1: After rst_ni is asserted, status_o is 0x14802000 and readback_o is 0. All geometry outputs read 0, and cmd_flush_o is low.
- R2: A write of command 0x00 returns status_o, readback_o and every geometry output to their R1 values. It also reloads environment register i with the value (0xE0+i) in bits 31:24 and zeros in all lower bits.
- R3: cmd_flush_o is high for exactly the one cycle after the clock edge of a command 0x00 or 0x01 write. Command 0x01 changes no other output.
- R4: Command 0x03 copies data bit 0 into status bit 23, which blank_o mirrors. All other status bits stay as they were.
- R5: Command 0x04 copies data bits 1:0 into status bits 30:29, which dma_dir_o mirrors. All other status bits stay as they were.
- R6: Command 0x05 latches start_x_o from data bits 9:0 and start_y_o from data bits 18:10.
- R7: Command 0x06 latches h_start_o from data bits 11:0 and h_end_o from data bits 23:12. Command 0x07 latches v_start_o from data bits 9:0 and v_end_o from data bits 19:10.
- R8: Command 0x08 writes data bits 5:0 to status bits 22:17 and data bit 6 to status bit 16. All other status bits stay as they were. mode_o equals status bits 22:16.
- R9: For commands 0x10 to 0x1F, data bits 3:0 select the query. A value of 2, 3 or 4 loads readback_o with that environment register ANDed with 0x000FFFFF. A value of 5 loads environment register 5 ANDed with 0x003FFFFF.
- R10: A query value of 7 loads readback_o with 2. Any query value other than 2, 3, 4, 5 or 7 leaves readback_o unchanged.
- R11: When env_we_i is high and env_data_i bits 31:27 are 11100, env_data_i is stored into the environment register selected by bits 26:24. An environment write whose top bits differ is ignored.
- R12: Outputs update in the cycle after the write's clock edge. A value read during the write cycle is the value from before the write.
- R13: Commands 0x02, 0x09 to 0x0F and 0x20 to 0xFF leave status_o, readback_o and the geometry outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 32 | Control word: command in bits 31:24, parameters in the bits below |
| env_we_i | input | 1 | Drawing-environment write strobe |
| env_data_i | input | 32 | Drawing-environment word |
| status_o | output | 32 | Status word |
| readback_o | output | 32 | Information-query result |
| start_x_o | output | 10 | Scanout start X |
| start_y_o | output | 9 | Scanout start Y |
| h_start_o | output | 12 | Horizontal range start |
| h_end_o | output | 12 | Horizontal range end |
| v_start_o | output | 10 | Vertical range start |
| v_end_o | output | 10 | Vertical range end |
| dma_dir_o | output | 2 | DMA direction (status bits 30:29) |
| blank_o | output | 1 | Blanking flag (status bit 23) |
| mode_o | output | 7 | Mode bits (status bits 22:16) |
| cmd_flush_o | output | 1 | One-cycle command FIFO flush pulse |

## Verification
Two events can fall in the same cycle: an environment-register write, and an information query or full reset arriving on the control port. The bench provokes this by driving both strobes on one edge. It checks that a query returns the value from before the environment write, and that a full reset overrides a concurrent environment write. A status write is also sampled just before its edge to confirm that the old word is still visible, and again after the edge to confirm the new word.

// File: rtl/disp_ctrl_pkg.sv
package disp_ctrl_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned NUM_ENV = 8;

  localparam logic [WORD_W-1:0] STATUS_RST = 32'h1480_2000;

  localparam logic [CMD_W-1:0] CMD_FULL_RST  = 8'h00;
  localparam logic [CMD_W-1:0] CMD_FLUSH     = 8'h01;
  localparam logic [CMD_W-1:0] CMD_BLANK     = 8'h03;
  localparam logic [CMD_W-1:0] CMD_DMA       = 8'h04;
  localparam logic [CMD_W-1:0] CMD_START     = 8'h05;
  localparam logic [CMD_W-1:0] CMD_HRANGE    = 8'h06;
  localparam logic [CMD_W-1:0] CMD_VRANGE    = 8'h07;
  localparam logic [CMD_W-1:0] CMD_MODE      = 8'h08;
  localparam logic [3:0]       CMD_QUERY_HI  = 4'h1;

  localparam int unsigned BLANK_BIT = 23;
  localparam int unsigned DMA_LO    = 29;
  localparam int unsigned MODE_LO   = 16;
  localparam int unsigned MODE_W    = 7;

  localparam logic [4:0] ENV_TAG = 5'b11100;

  function automatic logic [WORD_W-1:0] env_reset_val(input int unsigned idx);
    logic [CMD_W-1:0] tag;
    tag = 8'hE0 + CMD_W'(idx);
    return {tag, 24'h0};
  endfunction
endpackage

// File: rtl/disp_status_reg.sv
module disp_status_reg
  import disp_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [6:0]        arg_i,
  output logic [WORD_W-1:0] status_o
);
  logic [WORD_W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= STATUS_RST;
    end else if (we_i) begin
      case (cmd_i)
        CMD_FULL_RST: st_q <= STATUS_RST;
        CMD_BLANK:    st_q[BLANK_BIT] <= arg_i[0];
        CMD_DMA:      st_q[DMA_LO+1:DMA_LO] <= arg_i[1:0];
        CMD_MODE:     st_q[MODE_LO+MODE_W-1:MODE_LO] <= {arg_i[5:0], arg_i[6]};
        default: ;
      endcase
    end
  end

  assign status_o = st_q;

  assert_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd_i == CMD_BLANK) |=> (status_o[BLANK_BIT] == $past(arg_i[0])));
  assert_dma_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd_i == CMD_DMA) |=> (status_o[DMA_LO+1:DMA_LO] == $past(arg_i[1:0])));
  assert_mode_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd_i == CMD_MODE) |=> (status_o[15:0] == $past(status_o[15:0])));
  assert_full_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd_i == CMD_FULL_RST) |=> (status_o == STATUS_RST));
  assert_other_stable_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd_i > CMD_MODE) |=> $stable(status_o));
endmodule

// File: rtl/disp_range_regs.sv
module disp_range_regs
  import disp_ctrl_pkg::*;
#(
  parameter int unsigned SX_W = 10,
  parameter int unsigned SY_W = 9,
  parameter int unsigned H_W  = 12,
  parameter int unsigned V_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [SX_W-1:0]   start_x_o,
  output logic [SY_W-1:0]   start_y_o,
  output logic [H_W-1:0]    h_start_o,
  output logic [H_W-1:0]    h_end_o,
  output logic [V_W-1:0]    v_start_o,
  output logic [V_W-1:0]    v_end_o
);
  logic [CMD_W-1:0] cmd;
  assign cmd = data_i[WORD_W-1 -: CMD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_x_o <= '0; start_y_o <= '0;
      h_start_o <= '0; h_end_o   <= '0;
      v_start_o <= '0; v_end_o   <= '0;
    end else if (we_i) begin
      case (cmd)
        CMD_FULL_RST: begin
          start_x_o <= '0; start_y_o <= '0;
          h_start_o <= '0; h_end_o   <= '0;
          v_start_o <= '0; v_end_o   <= '0;
        end
        CMD_START: begin
          start_x_o <= data_i[SX_W-1:0];
          start_y_o <= data_i[SX_W +: SY_W];
        end
        CMD_HRANGE: begin
          h_start_o <= data_i[H_W-1:0];
          h_end_o   <= data_i[H_W +: H_W];
        end
        CMD_VRANGE: begin
          v_start_o <= data_i[V_W-1:0];
          v_end_o   <= data_i[V_W +: V_W];
        end
        default: ;
      endcase
    end
  end

  assert_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd == CMD_START) |=> (start_x_o == $past(data_i[SX_W-1:0])));
  assert_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd > CMD_MODE) |=> ($stable(h_end_o) && $stable(v_end_o) && $stable(start_y_o)));
endmodule

// File: rtl/disp_info_query.sv
module disp_info_query
  import disp_ctrl_pkg::*;
#(
  parameter int unsigned N_ENV = NUM_ENV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [3:0]        sel_i,
  input  logic              env_we_i,
  input  logic [WORD_W-1:0] env_data_i,
  output logic [WORD_W-1:0] readback_o
);
  localparam int unsigned IDX_W = $clog2(N_ENV);

  logic [WORD_W-1:0] env_q [N_ENV];
  logic              full_rst, is_query, env_hit;
  logic [IDX_W-1:0]  env_idx;

  assign full_rst = we_i && (cmd_i == CMD_FULL_RST);
  assign is_query = we_i && (cmd_i[7:4] == CMD_QUERY_HI);
  assign env_hit  = env_we_i && (env_data_i[31:27] == ENV_TAG);
  assign env_idx  = env_data_i[24 +: IDX_W];

  for (genvar g = 0; g < N_ENV; g++) begin : g_env
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                env_q[g] <= env_reset_val(g);
      else if (full_rst)                          env_q[g] <= env_reset_val(g);
      else if (env_hit && env_idx == IDX_W'(g))   env_q[g] <= env_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      readback_o <= '0;
    end else if (full_rst) begin
      readback_o <= '0;
    end else if (is_query) begin
      case (sel_i)
        4'h2, 4'h3, 4'h4: readback_o <= env_q[sel_i[IDX_W-1:0]] & 32'h000F_FFFF;
        4'h5:             readback_o <= env_q[5] & 32'h003F_FFFF;
        4'h7:             readback_o <= 32'd2;
        default: ;
      endcase
    end
  end

  assert_query_const_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_query && sel_i == 4'h7) |=> (readback_o == 32'd2));
  assert_query_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_query && !(sel_i inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h7})) |=> $stable(readback_o));
  assert_query_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_query && sel_i == 4'h3) |=> (readback_o[31:20] == 12'h0));
endmodule

// File: rtl/disp_ctrl_dec.sv
module disp_ctrl_dec
  import disp_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        env_we_i,
  input  logic [31:0] env_data_i,
  output logic [31:0] status_o,
  output logic [31:0] readback_o,
  output logic [9:0]  start_x_o,
  output logic [8:0]  start_y_o,
  output logic [11:0] h_start_o,
  output logic [11:0] h_end_o,
  output logic [9:0]  v_start_o,
  output logic [9:0]  v_end_o,
  output logic [1:0]  dma_dir_o,
  output logic        blank_o,
  output logic [6:0]  mode_o,
  output logic        cmd_flush_o
);
  logic [CMD_W-1:0] cmd;
  logic             flush_q;

  assign cmd = wr_data_i[WORD_W-1 -: CMD_W];

  disp_status_reg u_status (
    .clk_i, .rst_ni,
    .we_i    (wr_en_i),
    .cmd_i   (cmd),
    .arg_i   (wr_data_i[6:0]),
    .status_o(status_o)
  );

  disp_range_regs #(.SX_W(10), .SY_W(9), .H_W(12), .V_W(10)) u_range (
    .clk_i, .rst_ni,
    .we_i     (wr_en_i),
    .data_i   (wr_data_i),
    .start_x_o(start_x_o),
    .start_y_o(start_y_o),
    .h_start_o(h_start_o),
    .h_end_o  (h_end_o),
    .v_start_o(v_start_o),
    .v_end_o  (v_end_o)
  );

  disp_info_query #(.N_ENV(NUM_ENV)) u_query (
    .clk_i, .rst_ni,
    .we_i      (wr_en_i),
    .cmd_i     (cmd),
    .sel_i     (wr_data_i[3:0]),
    .env_we_i  (env_we_i),
    .env_data_i(env_data_i),
    .readback_o(readback_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= wr_en_i && (cmd == CMD_FULL_RST || cmd == CMD_FLUSH);
  end

  assign cmd_flush_o = flush_q;
  assign dma_dir_o   = status_o[DMA_LO+1:DMA_LO];
  assign blank_o     = status_o[BLANK_BIT];
  assign mode_o      = status_o[MODE_LO +: MODE_W];

  assert_flush_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_flush_o |-> $past(wr_en_i && (cmd == CMD_FULL_RST || cmd == CMD_FLUSH)));
  assert_flush_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cmd == CMD_FLUSH) |=> ($stable(status_o) && $stable(readback_o)));
endmodule

// File: tb/disp_ctrl_dec_tb.sv
module disp_ctrl_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        env_we_i = 1'b0;
  logic [31:0] env_data_i = '0;
  logic [31:0] status_o, readback_o;
  logic [9:0]  start_x_o, v_start_o, v_end_o;
  logic [8:0]  start_y_o;
  logic [11:0] h_start_o, h_end_o;
  logic [1:0]  dma_dir_o;
  logic        blank_o, cmd_flush_o;
  logic [6:0]  mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disp_ctrl_dec dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_data_i, .env_we_i, .env_data_i,
    .status_o, .readback_o, .start_x_o, .start_y_o, .h_start_o, .h_end_o,
    .v_start_o, .v_end_o, .dma_dir_o, .blank_o, .mode_o, .cmd_flush_o
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive on negedge, commit on posedge, return at next negedge
  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic env_wr(input logic [31:0] d);
    @(negedge clk); env_we_i = 1'b1; env_data_i = d;
    @(negedge clk); env_we_i = 1'b0; env_data_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 status", status_o, 32'h1480_2000);
    chk("R1 readback", readback_o, 0);
    chk("R1 fields", {start_x_o, h_end_o, v_end_o}, 0);
    chk("R1 flush", cmd_flush_o, 0);
    chk("R4 blank at reset", blank_o, 1);
  endtask

  task automatic t_blank;
    wr(32'h0300_0000);
    chk("R4 clear", status_o, 32'h1400_2000);
    wr(32'h0300_0001);
    chk("R4 set", status_o, 32'h1480_2000);
  endtask

  task automatic t_dma;
    wr(32'h0400_0003);
    chk("R5 dma3", status_o, 32'h7480_2000);
    wr(32'h0400_0001);
    chk("R5 dma1 status", status_o, 32'h3480_2000);
    chk("R5 dma_dir_o", dma_dir_o, 2'd1);
  endtask

  task automatic t_start;
    wr(32'h0507_FFFF);
    chk("R6 x max", start_x_o, 10'h3FF);
    chk("R6 y max", start_y_o, 9'h1FF);
    wr(32'h0500_0C05);
    chk("R6 x", start_x_o, 10'd5);
    chk("R6 y", start_y_o, 9'd3);
  endtask

  task automatic t_ranges;
    wr(32'h06C6_0260);
    chk("R7 h start", h_start_o, 12'h260);
    chk("R7 h end", h_end_o, 12'hC60);
    wr(32'h0704_0010);
    chk("R7 v start", v_start_o, 10'h010);
    chk("R7 v end", v_end_o, 10'h100);
  endtask

  task automatic t_mode;
    wr(32'h0800_0041);
    chk("R8 status", status_o, 32'h3483_2000);
    chk("R8 mode_o", mode_o, 7'h03);
    wr(32'h0800_007F);
    chk("R8 all ones", status_o, 32'h34FF_2000);
  endtask

  task automatic t_query;
    wr(32'h1000_0002);
    chk("R9 env2 reset", readback_o, 0);
    env_wr(32'hE3AB_CDEF);
    wr(32'h1000_0003);
    chk("R9 R11 env3", readback_o, 32'h000B_CDEF);
    env_wr(32'hE5FF_FFFF);
    wr(32'h1F00_0005);
    chk("R9 env5 mask", readback_o, 32'h003F_FFFF);
    wr(32'h1000_0007);
    chk("R10 const", readback_o, 32'd2);
    wr(32'h1000_000A);
    chk("R10 unchanged", readback_o, 32'd2);
    wr(32'h1000_0013);
    chk("R9 low nibble only", readback_o, 32'h000B_CDEF);
  endtask

  task automatic t_env_ignore;
    env_wr(32'hD312_3456);
    wr(32'h1000_0003);
    chk("R11 ignored", readback_o, 32'h000B_CDEF);
  endtask

  task automatic t_unknown;
    logic [31:0] st;
    st = status_o;
    wr(32'h09FF_FFFF);
    wr(32'h20FF_FFFF);
    wr(32'h02FF_FFFF);
    chk("R13 status", status_o, st);
    chk("R13 readback", readback_o, 32'h000B_CDEF);
    chk("R13 fields", {h_end_o, v_end_o, start_x_o}, {12'hC60, 10'h100, 10'd5});
  endtask

  task automatic t_same_cycle;
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 32'h0300_0000;
    env_we_i = 1'b1; env_data_i = 32'hE300_0001;
    #1 chk("R12 old before edge", status_o, 32'h34FF_2000);
    @(negedge clk); wr_en_i = 1'b0; env_we_i = 1'b0;
    chk("R12 new after edge", status_o, 32'h347F_2000);
    // query alongside environment write sees the old value
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 32'h1000_0003;
    env_we_i = 1'b1; env_data_i = 32'hE300_0055;
    @(negedge clk); wr_en_i = 1'b0; env_we_i = 1'b0;
    chk("R12 query old env", readback_o, 32'h0000_0001);
    wr(32'h1000_0003);
    chk("R11 env updated", readback_o, 32'h0000_0055);
  endtask

  task automatic t_flush;
    wr(32'h0100_0000);
    chk("R3 pulse high", cmd_flush_o, 1);
    chk("R3 status kept", status_o, 32'h347F_2000);
    @(negedge clk);
    chk("R3 pulse low", cmd_flush_o, 0);
  endtask

  task automatic t_full_reset;
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 32'h0000_0000;
    env_we_i = 1'b1; env_data_i = 32'hE3AA_AAAA;
    @(negedge clk); wr_en_i = 1'b0; env_we_i = 1'b0;
    chk("R2 status", status_o, 32'h1480_2000);
    chk("R2 readback", readback_o, 0);
    chk("R2 fields", {start_x_o, start_y_o, h_start_o, v_start_o}, 0);
    chk("R2 R3 flush", cmd_flush_o, 1);
    wr(32'h1000_0003);
    chk("R2 env3 reloaded", readback_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_blank();
    t_dma();
    t_start();
    t_ranges();
    t_mode();
    t_query();
    t_env_ignore();
    t_unknown();
    t_same_cycle();
    t_flush();
    t_full_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule